// File: doc/BRIEF.md
# PCI Interrupt Router With Acknowledge Register

This block gathers the four level-sensitive interrupt pins (A, B, C, D) of a set of PCI devices and turns them into host interrupt requests. Each device reports its device number next to its pins. A fixed swizzle folds every pin onto one of two bus interrupt lines, chosen by the pin's index and the device number. A mode strap selects how those lines leave the block. In separate-line mode each bus line drives its own host output. In shared mode every bus line is ORed onto one output, which the platform wires to host IRQ 15.

The block also decodes one byte-wide register in the CPU address space, which the CPU reads to acknowledge an interrupt. A byte read there returns the vector offered by an external interrupt controller and sends that controller a one-cycle acknowledge pulse. Writes complete but change nothing. Accesses wider than a byte are rejected with an error response. The interrupt controller and its priority logic sit outside this block.

Top module: `pci_irq_router`

## Requirements
- R1: Pin p of a device (A=0, B=1, C=2, D=3; bit 4k+p of `dev_pins` for device k) maps to bus line (p + d) mod 2. Here d is the device number, the device/function byte shifted right by 3, given on bits [5k+4:5k] of `dev_nums`. Bus lines 2 and 3 are therefore never asserted.
- R2: A bus line is asserted while any pin mapped to it is asserted, and drops once none is. Host outputs are registered and follow the inputs one clock later.
- R3: With `legacy_mode`=1, `host_lines[i]` carries bus line i for i in 0..3 and `shared_irq` stays 0.
- R4: With `legacy_mode`=0, `shared_irq` is the OR of all bus lines and `host_lines` stays 0.
- R5: A request with `cpu_req`=1, `cpu_wr`=0, `cpu_size`=0 (byte) and `cpu_addr`=ACK_ADDR (default 0xBFFF_FFF0) produces, in the next cycle, `rsp_valid`=1, `rsp_err`=0, a single-cycle `ctl_ack` pulse and `rsp_data` equal to `ctl_vector` as sampled at the request edge.
- R6: A request to ACK_ADDR with `cpu_size` not 0 (1 = halfword, 2 = word) gets, in the next cycle, `rsp_valid`=1, `rsp_err`=1, `rsp_data`=0 and no `ctl_ack`.
- R7: A byte write to ACK_ADDR gets, in the next cycle, `rsp_valid`=1, `rsp_err`=0, `rsp_data`=0 and no `ctl_ack`.
- R8: A request to any other address, and any idle cycle, leaves `rsp_valid` and `ctl_ack` at 0 in the next cycle.
- R9: While `rst_n` is low at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_mode | input | 1 | 1: separate host lines, 0: one shared output |
| dev_pins | input | NUM_DEV*4 | Interrupt pin levels, four per device |
| dev_nums | input | NUM_DEV*5 | Device number of each device |
| ctl_vector | input | VEC_W | Pending vector from the interrupt controller |
| ctl_ack | output | 1 | One-cycle acknowledge pulse to the controller |
| cpu_req | input | 1 | CPU access strobe |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| rsp_valid | output | 1 | Response for an access to the acknowledge register |
| rsp_err | output | 1 | Access width rejected |
| rsp_data | output | VEC_W | Read data |
| host_lines | output | 4 | Separate host interrupt outputs |
| shared_irq | output | 1 | Shared host interrupt output |

## Verification
Routing and acknowledge can fall in the same cycle. A byte read of the acknowledge register may arrive while device pins toggle, while the mode strap flips, or while the vector itself changes. The bench drives pins, device numbers, mode, vector and CPU accesses independently every cycle, so these coincidences occur often. A reference model checks both groups of outputs on every clock. A read must return the vector present at its own request edge, and the routed levels must not be disturbed by the access.

// File: rtl/irq_rtr_pkg.sv
// Package: shared constants and access-size encoding for the interrupt router.
// Assumes: conventional PCI with four interrupt pins per device.
package irq_rtr_pkg;
    localparam int NUM_PINS      = 4;  // interrupt pins A..D per device
    localparam int SWIZZLE_LINES = 2;  // bus lines the swizzle folds onto
    localparam int DEVNUM_W      = 5;  // device number width
    localparam int LINE_IDX_W    = $clog2(NUM_PINS);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } access_size_e;
endpackage

// File: rtl/irq_pin_swizzle.sv
// Module: irq_pin_swizzle
// Maps the four interrupt pins of one device onto bus lines using
// (pin index + device number) mod SWIZZLE_LINES. Purely combinational.
// Assumes: pins are level-sensitive and already synchronous to clk.
module irq_pin_swizzle
    import irq_rtr_pkg::*;
(
    input  logic [NUM_PINS-1:0] pins,
    input  logic [DEVNUM_W-1:0] dev_num,
    output logic [NUM_PINS-1:0] lines
);

    // Selects the bus line index for a pin of this device.
    function automatic logic [LINE_IDX_W-1:0] line_of(input int pin_idx,
                                                      input logic [DEVNUM_W-1:0] dn);
        int sum;
        sum = (pin_idx + int'(dn)) % SWIZZLE_LINES;
        return LINE_IDX_W'(sum);
    endfunction

    // Scatters each asserted pin onto its mapped bus line.
    always_comb begin
        lines = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pins[p]) begin
                lines[line_of(p, dev_num)] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_line_router.sv
// Module: irq_line_router
// ORs the per-device bus line vectors into the four bus lines and, per
// the mode strap, drives either the separate host outputs or the single
// shared output. Outputs are registered.
// Assumes: synchronous active-low reset; mode strap is static or glitch-free.
module irq_line_router
    import irq_rtr_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        legacy_mode,
    input  logic [NUM_DEV*NUM_PINS-1:0] dev_lines,
    output logic [NUM_PINS-1:0]         host_lines,
    output logic                        shared_irq
);

    logic [NUM_PINS-1:0] merged;
    logic [NUM_PINS-1:0] host_nxt;
    logic                shared_nxt;

    // Level-ORs every device's contribution to each bus line.
    always_comb begin
        merged = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            merged = merged | dev_lines[d*NUM_PINS +: NUM_PINS];
        end
    end

    // Picks separate lines or the shared output from the mode strap.
    always_comb begin
        if (legacy_mode) begin
            host_nxt   = merged;
            shared_nxt = 1'b0;
        end else begin
            host_nxt   = '0;
            shared_nxt = |merged;
        end
    end

    // Registers the host outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_lines <= '0;
            shared_irq <= 1'b0;
        end else begin
            host_lines <= host_nxt;
            shared_irq <= shared_nxt;
        end
    end

    AST_SHARED_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_mode && (|dev_lines)) |=> shared_irq); // R4
    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(shared_irq && (|host_lines))); // R3
    AST_UPPER_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_lines[NUM_PINS-1:SWIZZLE_LINES] == '0); // R1
    AST_LEGACY_NO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode |=> !shared_irq); // R3

endmodule

// File: rtl/irq_ack_port.sv
// Module: irq_ack_port
// Decodes the one-byte acknowledge register. A byte read returns the
// controller's vector and pulses the acknowledge for one cycle; writes
// complete without effect; wider accesses are answered with an error.
// Assumes: one access per cycle, response in the following cycle.
module irq_ack_port
    import irq_rtr_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              VEC_W    = 8,
    parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic [VEC_W-1:0]  ctl_vector,
    output logic              ctl_ack,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [VEC_W-1:0]  rsp_data
);

    logic hit;
    logic byte_acc;
    logic take_vec;

    // Address decode and access qualification.
    always_comb begin
        hit      = cpu_req && (cpu_addr == ACK_ADDR);
        byte_acc = (cpu_size == SZ_BYTE);
        take_vec = hit && !cpu_wr && byte_acc;
    end

    // Registers the response and the acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            ctl_ack   <= 1'b0;
        end else begin
            rsp_valid <= hit;
            rsp_err   <= hit && !byte_acc;
            rsp_data  <= take_vec ? ctl_vector : '0;
            ctl_ack   <= take_vec;
        end
    end

    AST_ACK_CLEAN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ack |-> (rsp_valid && !rsp_err)); // R5
    AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_wr && cpu_size == SZ_BYTE && cpu_addr == ACK_ADDR)
        |=> (rsp_data == $past(ctl_vector))); // R5
    AST_WIDE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_addr == ACK_ADDR && cpu_size != SZ_BYTE)
        |=> (rsp_err && !ctl_ack)); // R6
    AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_wr) |=> !ctl_ack); // R7
    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req || cpu_addr != ACK_ADDR) |=> (!rsp_valid && !ctl_ack)); // R8

endmodule

// File: rtl/pci_irq_router.sv
// Module: pci_irq_router (top)
// Swizzles device interrupt pins onto bus lines, routes them to separate
// or shared host outputs, and provides the interrupt acknowledge register.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module pci_irq_router
    import irq_rtr_pkg::*;
#(
    parameter int              NUM_DEV  = 4,
    parameter int              ADDR_W   = 32,
    parameter int              VEC_W    = 8,
    parameter logic [ADDR_W-1:0] ACK_ADDR = 32'hBFFF_FFF0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        legacy_mode,
    input  logic [NUM_DEV*NUM_PINS-1:0] dev_pins,
    input  logic [NUM_DEV*DEVNUM_W-1:0] dev_nums,
    input  logic [VEC_W-1:0]            ctl_vector,
    output logic                        ctl_ack,
    input  logic                        cpu_req,
    input  logic                        cpu_wr,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [1:0]                  cpu_size,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [VEC_W-1:0]            rsp_data,
    output logic [NUM_PINS-1:0]         host_lines,
    output logic                        shared_irq
);

    logic [NUM_DEV*NUM_PINS-1:0] dev_lines;

    // One swizzle per device.
    for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
        irq_pin_swizzle u_swz (
            .pins    (dev_pins[k*NUM_PINS +: NUM_PINS]),
            .dev_num (dev_nums[k*DEVNUM_W +: DEVNUM_W]),
            .lines   (dev_lines[k*NUM_PINS +: NUM_PINS])
        );
    end

    irq_line_router #(
        .NUM_DEV (NUM_DEV)
    ) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .legacy_mode (legacy_mode),
        .dev_lines   (dev_lines),
        .host_lines  (host_lines),
        .shared_irq  (shared_irq)
    );

    irq_ack_port #(
        .ADDR_W   (ADDR_W),
        .VEC_W    (VEC_W),
        .ACK_ADDR (ACK_ADDR)
    ) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_size   (cpu_size),
        .ctl_vector (ctl_vector),
        .ctl_ack    (ctl_ack),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_data   (rsp_data)
    );

endmodule

// File: tb/pci_irq_router_tb.sv
// Bench: behavioural reference model compared against the DUT every clock.
module pci_irq_router_tb;
    localparam int ND  = 4;
    localparam logic [31:0] ACK = 32'hBFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_mode = 1'b1;
    logic [ND*4-1:0] dev_pins = '0;
    logic [ND*5-1:0] dev_nums = '0;
    logic [7:0]  ctl_vector = '0;
    logic        ctl_ack;
    logic        cpu_req = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic        rsp_valid, rsp_err;
    logic [7:0]  rsp_data;
    logic [3:0]  host_lines;
    logic        shared_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    logic [3:0] e_host;
    logic       e_shared, e_rv, e_err, e_ack;
    logic [7:0] e_data;
    string      tag_irq, tag_acc;

    always #10 clk = ~clk;

    pci_irq_router #(.NUM_DEV(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .dev_pins(dev_pins), .dev_nums(dev_nums), .ctl_vector(ctl_vector),
        .ctl_ack(ctl_ack), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .host_lines(host_lines),
        .shared_irq(shared_irq)
    );

    // Reference model: expected outputs after each rising edge.
    always @(posedge clk) begin
        logic [3:0] lines;
        bit hit;
        model_on <= 1'b1;
        if (!rst_n) begin
            e_host = '0; e_shared = 0; e_rv = 0; e_err = 0; e_ack = 0; e_data = '0;
            tag_irq = "R9"; tag_acc = "R9";
        end else begin
            lines = '0;
            for (int d = 0; d < ND; d++)
                for (int p = 0; p < 4; p++)
                    if (dev_pins[d*4+p]) lines[(p + int'(dev_nums[d*5 +: 5])) % 2] = 1'b1;
            if (legacy_mode) begin
                e_host = lines; e_shared = 0; tag_irq = "R1 R2 R3";
            end else begin
                e_host = '0; e_shared = |lines; tag_irq = "R1 R2 R4";
            end
            hit   = cpu_req && (cpu_addr == ACK);
            e_rv  = hit;
            e_err = hit && (cpu_size != 2'd0);
            e_ack = hit && !cpu_wr && (cpu_size == 2'd0);
            e_data = e_ack ? ctl_vector : 8'h00;
            if (!hit)                    tag_acc = "R8";
            else if (cpu_size != 2'd0)   tag_acc = "R6";
            else if (cpu_wr)             tag_acc = "R7";
            else                         tag_acc = "R5";
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (model_on && !done) begin
            check(host_lines == e_host, tag_irq, "host_lines", 32'(host_lines), 32'(e_host));
            check(shared_irq == e_shared, tag_irq, "shared_irq", 32'(shared_irq), 32'(e_shared));
            check(rsp_valid == e_rv, tag_acc, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
            check(rsp_err == e_err, tag_acc, "rsp_err", 32'(rsp_err), 32'(e_err));
            check(ctl_ack == e_ack, tag_acc, "ctl_ack", 32'(ctl_ack), 32'(e_ack));
            check(rsp_data == e_data, tag_acc, "rsp_data", 32'(rsp_data), 32'(e_data));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic idle_bus();
        cpu_req = 0; cpu_wr = 0; cpu_addr = '0; cpu_size = 0;
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz);
        cpu_req = 1; cpu_wr = wr; cpu_addr = a; cpu_size = sz;
    endtask

    initial begin
        // R9: reset state observed during reset cycles.
        dev_pins = '1;
        access(0, ACK, 0);
        ctl_vector = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dev_pins = '0;
        idle_bus();

        // R1 R3: walk single pins with even and odd device numbers, separate lines.
        legacy_mode = 1'b1;
        dev_nums = {5'd3, 5'd2, 5'd1, 5'd0};
        for (int i = 0; i < ND*4; i++) begin
            @(negedge clk);
            dev_pins = '0;
            dev_pins[i] = 1'b1;
        end
        @(negedge clk);
        dev_nums = {5'd31, 5'd16, 5'd7, 5'd12};
        for (int i = 0; i < ND*4; i++) begin
            @(negedge clk);
            dev_pins = '0;
            dev_pins[i] = 1'b1;
        end
        // R2: two pins on the same line, release one then the other.
        @(negedge clk); dev_pins = 16'h0005;
        @(negedge clk); dev_pins = 16'h0004;
        @(negedge clk); dev_pins = 16'h0000;

        // R4: shared mode.
        @(negedge clk); legacy_mode = 1'b0;
        for (int i = 0; i < ND*4; i++) begin
            @(negedge clk);
            dev_pins = '0;
            dev_pins[i] = 1'b1;
        end
        @(negedge clk); dev_pins = '0;

        // R5 R6 R7 R8: directed accesses.
        @(negedge clk); ctl_vector = 8'hC3; access(0, ACK, 0);
        @(negedge clk); ctl_vector = 8'h11; access(0, ACK, 0);
        @(negedge clk); access(0, ACK, 1);
        @(negedge clk); access(0, ACK, 2);
        @(negedge clk); access(1, ACK, 0);
        @(negedge clk); access(1, ACK, 2);
        @(negedge clk); access(0, ACK + 1, 0);
        @(negedge clk); access(0, ACK - 16, 0);
        @(negedge clk); idle_bus();

        // Mixed: pins, numbers, mode, vector and accesses all change together.
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            dev_pins   = 16'($urandom);
            if ($urandom_range(0, 7) == 0) dev_nums = 20'($urandom);
            if ($urandom_range(0, 15) == 0) legacy_mode = ~legacy_mode;
            ctl_vector = 8'($urandom);
            case ($urandom_range(0, 5))
                0, 1: access(0, ACK, 0);
                2:    access(1, ACK, 2'($urandom));
                3:    access(0, ACK, 2'($urandom_range(1, 3)));
                4:    access($urandom_range(0, 1) == 1, 32'($urandom), 2'($urandom));
                default: idle_bus();
            endcase
            if ($urandom_range(0, 199) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
        end
        @(negedge clk); idle_bus(); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule